// File: doc/BRIEF.md
# Instruction Byte Parser

The block consumes a stream of instruction bytes, taking one byte per cycle in which `in_valid` and `in_ready` are both high. It splits each instruction into an optional escape byte (0x0F), a primary opcode, an optional addressing byte, an optional displacement of 1 or 4 bytes and an optional 8-bit immediate. When the final byte of an instruction has been taken, a decoded record appears on the `rec_*` outputs for exactly one cycle. During that cycle `in_ready` is low. The parser then resumes fetching the next opcode.

Only a small opcode subset is recognised. Anything else is reported as illegal. The addressing byte carries the fields mod (bits 7:6), reg (bits 5:3) and rm (bits 2:0). The mod/rm pair decides how many displacement bytes follow. Scaled-index addressing is not handled and is flagged as unsupported.

The controller has six states:

| State | Role |
|---|---|
| `ST_OPC` | Opcode fetch. |
| `ST_OPC2` | Second-level opcode after the escape. |
| `ST_MODRM` | Addressing byte. |
| `ST_DISP` | Displacement collection. |
| `ST_IMM` | Immediate byte. |
| `ST_EMIT` | Record presentation. |

Its transitions are:

- **escape:** `ST_OPC` goes to `ST_OPC2`.
- **needs-addressing:** an opcode state goes to `ST_MODRM`.
- **needs-immediate:** an opcode, `ST_MODRM` or `ST_DISP` goes to `ST_IMM`.
- **done:** any collecting state goes to `ST_EMIT`.
- **disp-start:** `ST_MODRM` goes to `ST_DISP`.
- **disp-more:** `ST_DISP` stays in `ST_DISP`.
- **resume:** `ST_EMIT` goes to `ST_OPC`.

Top module: `insn_parser`

## Requirements
- R1: A synchronous active-high `rst` returns the parser to opcode fetch, even in the middle of an instruction. After reset `in_ready`=1 and `rec_valid`=0.
- R2: A first byte of 0x0F sets `rec_esc`, and the next byte is looked up in the second-level table only. For example, 0x0F 0x03 is illegal, while a plain 0x03 is an add.
- R3: The operation tag `rec_op` is encoded as follows. The supported opcodes listed below take an addressing byte.

  | `rec_op` | Meaning |
  |---|---|
  | 0 | illegal |
  | 1 | add register, from register or memory (0x03) |
  | 2 | add to register or memory (0x01) |
  | 3 | immediate group (0x80) |
  | 4 | no-op (0x90) |
  | 5 | double shift-left with immediate count (0x0F 0xA4) |
  | 6 | double shift-left with count in register (0x0F 0xA5) |

  The no-op has no addressing byte. `rec_mod`, `rec_reg` and `rec_rm` take addressing-byte bits 7:6, 5:3 and 2:0.
- R4: mod=00 with rm=101 means 4 displacement bytes follow. They arrive least-significant first and are assembled into `rec_disp`.
- R5: The displacement length depends on mod. mod=01 reads 1 displacement byte, sign-extended to 32 bits. mod=10 reads 4 bytes. mod=11 reads none.
- R6: Tags 3 and 5 take one immediate byte after any displacement. That byte is the last one of the instruction and appears on `rec_imm`.
- R7: For the group opcode 0x80, `rec_grp`=1, marking `rec_reg` as an opcode extension. It is 0 for every other opcode.
- R8: rm=100 with mod≠11 ends the instruction right after the addressing byte. It sets `rec_unsup`=1, and `rec_len` counts the bytes taken so far.
- R9: An unknown opcode sets `rec_illegal`=1 and `rec_op`=0, with `rec_len`=1, or 2 after an escape. The following byte is treated as a new opcode.
- R10: `rec_valid` lasts exactly one cycle. `in_ready` is low in that cycle only and high in the next one.
- R11: `rec_len` equals the number of bytes taken for the instruction, and idle cycles (`in_valid`=0) between bytes do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser accepts a byte |
| rec_valid | output | 1 | Decoded record valid, one cycle |
| rec_opcode | output | 8 | Primary opcode byte (after any escape) |
| rec_esc | output | 1 | Escape byte was present |
| rec_mod | output | 2 | Addressing mod field |
| rec_reg | output | 3 | Register field or opcode extension |
| rec_rm | output | 3 | Addressing rm field |
| rec_grp | output | 1 | reg field is an opcode extension |
| rec_disp | output | 32 | Assembled displacement |
| rec_imm | output | 8 | Immediate byte |
| rec_len | output | 4 | Total instruction length in bytes |
| rec_op | output | 3 | Operation tag |
| rec_illegal | output | 1 | Opcode not in the supported subset |
| rec_unsup | output | 1 | Scaled-index addressing requested |

## Verification
A wrong state shows up as a record whose `rec_len` or field alignment is off. Because every following instruction is then misframed, the error surfaces at the very next `rec_valid` pulse and usually in every record after it. A wrong displacement count also shifts the immediate into the displacement, so `rec_imm` and `rec_disp` both go wrong in the same pulse. A stuck `ST_EMIT` shows at once as `rec_valid` or a low `in_ready` persisting past one cycle.

// File: rtl/insn_parser_pkg.sv
package insn_parser_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h0F;

    typedef enum logic [OP_W-1:0] {
        OP_ILL    = 3'd0,
        OP_ADD_GE = 3'd1,
        OP_ADD_EG = 3'd2,
        OP_GRP1   = 3'd3,
        OP_NOP    = 3'd4,
        OP_SHLD_I = 3'd5,
        OP_SHLD_C = 3'd6
    } op_tag_e;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_OPC2,
        ST_MODRM,
        ST_DISP,
        ST_IMM,
        ST_EMIT
    } pstate_e;

    typedef struct packed {
        logic    legal;
        logic    has_modrm;
        logic    has_imm;
        logic    grp;
        op_tag_e tag;
    } op_info_t;

endpackage

// File: rtl/insn_optab.sv
module insn_optab
    import insn_parser_pkg::*;
(
    input  logic              second,
    input  logic [BYTE_W-1:0] code,
    output op_info_t          info
);
    always_comb begin
        info = '{legal: 1'b0, has_modrm: 1'b0, has_imm: 1'b0, grp: 1'b0, tag: OP_ILL};
        if (!second) begin
            unique case (code)
                8'h03: info = '{1'b1, 1'b1, 1'b0, 1'b0, OP_ADD_GE};
                8'h01: info = '{1'b1, 1'b1, 1'b0, 1'b0, OP_ADD_EG};
                8'h80: info = '{1'b1, 1'b1, 1'b1, 1'b1, OP_GRP1};
                8'h90: info = '{1'b1, 1'b0, 1'b0, 1'b0, OP_NOP};
                default: ;
            endcase
        end else begin
            unique case (code)
                8'hA4: info = '{1'b1, 1'b1, 1'b1, 1'b0, OP_SHLD_I};
                8'hA5: info = '{1'b1, 1'b1, 1'b0, 1'b0, OP_SHLD_C};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/insn_modrm_len.sv
module insn_modrm_len #(
    parameter int DISP_BYTES = 4,
    localparam int CNT_W = $clog2(DISP_BYTES + 1)
) (
    input  logic [7:0]       modrm,
    output logic [CNT_W-1:0] disp_cnt,
    output logic             disp_short,
    output logic             unsup
);
    logic [1:0] md;
    logic [2:0] rm;

    assign md = modrm[7:6];
    assign rm = modrm[2:0];

    always_comb begin
        disp_cnt   = '0;
        disp_short = 1'b0;
        unsup      = (md != 2'b11) && (rm == 3'b100);
        unique case (md)
            2'b00: if (rm == 3'b101) disp_cnt = CNT_W'(DISP_BYTES);
            2'b01: begin
                disp_cnt   = CNT_W'(1);
                disp_short = 1'b1;
            end
            2'b10: disp_cnt = CNT_W'(DISP_BYTES);
            default: ;
        endcase
        if (unsup) begin
            disp_cnt   = '0;
            disp_short = 1'b0;
        end
    end
endmodule

// File: rtl/insn_parser.sv
module insn_parser
    import insn_parser_pkg::*;
#(
    parameter int DISP_W = 32,
    localparam int DISP_BYTES = DISP_W / BYTE_W,
    localparam int CNT_W = $clog2(DISP_BYTES + 1),
    localparam int MAX_LEN = 3 + DISP_BYTES + 1,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              rec_valid,
    output logic [7:0]        rec_opcode,
    output logic              rec_esc,
    output logic [1:0]        rec_mod,
    output logic [2:0]        rec_reg,
    output logic [2:0]        rec_rm,
    output logic              rec_grp,
    output logic [DISP_W-1:0] rec_disp,
    output logic [7:0]        rec_imm,
    output logic [LEN_W-1:0]  rec_len,
    output logic [2:0]        rec_op,
    output logic              rec_illegal,
    output logic              rec_unsup
);
    pstate_e state_q, state_d;

    logic              take;
    op_info_t          info;
    logic [CNT_W-1:0]  mr_cnt;
    logic              mr_short;
    logic              mr_unsup;

    logic [7:0]        opc_q;
    logic              esc_q;
    logic [1:0]        mod_q;
    logic [2:0]        reg_q;
    logic [2:0]        rm_q;
    logic              grp_q;
    logic              imm_need_q;
    logic [DISP_W-1:0] disp_q;
    logic [7:0]        imm_q;
    logic [LEN_W-1:0]  len_q;
    op_tag_e           tag_q;
    logic              ill_q;
    logic              uns_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic              short_q;

    assign in_ready = (state_q != ST_EMIT);
    assign take     = in_valid && in_ready;

    insn_optab u_optab (
        .second (state_q == ST_OPC2),
        .code   (in_byte),
        .info   (info)
    );

    insn_modrm_len #(.DISP_BYTES(DISP_BYTES)) u_modrm (
        .modrm      (in_byte),
        .disp_cnt   (mr_cnt),
        .disp_short (mr_short),
        .unsup      (mr_unsup)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OPC;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPC, ST_OPC2: if (take) begin
                if (state_q == ST_OPC && in_byte == ESC_BYTE) state_d = ST_OPC2;
                else if (!info.legal)                         state_d = ST_EMIT;
                else if (info.has_modrm)                      state_d = ST_MODRM;
                else if (info.has_imm)                        state_d = ST_IMM;
                else                                          state_d = ST_EMIT;
            end
            ST_MODRM: if (take) begin
                if (mr_unsup)                state_d = ST_EMIT;
                else if (mr_cnt != '0)       state_d = ST_DISP;
                else if (imm_need_q)         state_d = ST_IMM;
                else                         state_d = ST_EMIT;
            end
            ST_DISP: if (take && (idx_q + CNT_W'(1) == cnt_q))
                state_d = imm_need_q ? ST_IMM : ST_EMIT;
            ST_IMM:  if (take) state_d = ST_EMIT;
            ST_EMIT: state_d = ST_OPC;
            default: state_d = ST_OPC;
        endcase
    end

    // Record fields
    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q <= '0; esc_q <= 1'b0; mod_q <= '0; reg_q <= '0; rm_q <= '0;
            grp_q <= 1'b0; imm_need_q <= 1'b0; disp_q <= '0; imm_q <= '0;
            len_q <= '0; tag_q <= OP_ILL; ill_q <= 1'b0; uns_q <= 1'b0;
            cnt_q <= '0; idx_q <= '0; short_q <= 1'b0;
        end else if (take) begin
            len_q <= len_q + LEN_W'(1);
            unique case (state_q)
                ST_OPC, ST_OPC2: begin
                    if (state_q == ST_OPC) begin
                        esc_q  <= (in_byte == ESC_BYTE);
                        len_q  <= LEN_W'(1);
                        mod_q  <= '0; reg_q <= '0; rm_q <= '0;
                        disp_q <= '0; imm_q <= '0; uns_q <= 1'b0;
                    end
                    opc_q      <= in_byte;
                    grp_q      <= info.grp;
                    imm_need_q <= info.has_imm;
                    tag_q      <= info.tag;
                    ill_q      <= !info.legal;
                end
                ST_MODRM: begin
                    mod_q   <= in_byte[7:6];
                    reg_q   <= in_byte[5:3];
                    rm_q    <= in_byte[2:0];
                    uns_q   <= mr_unsup;
                    cnt_q   <= mr_cnt;
                    short_q <= mr_short;
                    idx_q   <= '0;
                end
                ST_DISP: begin
                    if (short_q) begin
                        disp_q <= {{(DISP_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte};
                    end else begin
                        for (int i = 0; i < DISP_BYTES; i++)
                            if (idx_q == CNT_W'(i)) disp_q[i*BYTE_W +: BYTE_W] <= in_byte;
                    end
                    idx_q <= idx_q + CNT_W'(1);
                end
                ST_IMM:  imm_q <= in_byte;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rec_valid   = (state_q == ST_EMIT);
        rec_opcode  = opc_q;
        rec_esc     = esc_q;
        rec_mod     = mod_q;
        rec_reg     = reg_q;
        rec_rm      = rm_q;
        rec_grp     = grp_q;
        rec_disp    = disp_q;
        rec_imm     = imm_q;
        rec_len     = len_q;
        rec_op      = tag_q;
        rec_illegal = ill_q;
        rec_unsup   = uns_q;
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid); // R10
    AST_READY_RESUMES: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> in_ready); // R10
    AST_ILL_LEN: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_illegal) |-> (rec_len == (rec_esc ? LEN_W'(2) : LEN_W'(1))) && (rec_op == 3'd0)); // R9
    AST_SHORT_SEXT: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_mod == 2'b01 && !rec_unsup && !rec_illegal)
        |-> (rec_disp[DISP_W-1:BYTE_W] == {(DISP_W-BYTE_W){rec_disp[BYTE_W-1]}})); // R5
    AST_UNSUP_LEN: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_unsup) |-> (rec_len == (rec_esc ? LEN_W'(3) : LEN_W'(2)))); // R8
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_len >= LEN_W'(1)) && (rec_len <= LEN_W'(MAX_LEN))); // R11
    AST_GRP_ONLY: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_grp) |-> (rec_op == 3'd3)); // R7

endmodule

// File: tb/tb_insn_parser.sv
module tb_insn_parser;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  opc;
        logic        esc;
        logic [1:0]  md;
        logic [2:0]  rg;
        logic [2:0]  rm;
        logic        grp;
        logic [31:0] disp;
        logic [7:0]  imm;
        logic [3:0]  len;
        logic [2:0]  op;
        logic        ill;
        logic        uns;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready, rec_valid, rec_esc, rec_grp, rec_illegal, rec_unsup;
    logic [7:0]  rec_opcode, rec_imm;
    logic [1:0]  rec_mod;
    logic [2:0]  rec_reg, rec_rm, rec_op;
    logic [31:0] rec_disp;
    logic [3:0]  rec_len;

    int checks = 0;
    int fails  = 0;
    rec_t  exp_q[$];
    string tag_q[$];
    logic  prev_v = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_parser dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rec_valid(rec_valid), .rec_opcode(rec_opcode),
        .rec_esc(rec_esc), .rec_mod(rec_mod), .rec_reg(rec_reg), .rec_rm(rec_rm),
        .rec_grp(rec_grp), .rec_disp(rec_disp), .rec_imm(rec_imm),
        .rec_len(rec_len), .rec_op(rec_op), .rec_illegal(rec_illegal),
        .rec_unsup(rec_unsup)
    );

    function automatic rec_t mk(input logic [7:0] opc, input logic esc, input logic [7:0] modrm,
                                input logic [31:0] disp, input logic [7:0] imm,
                                input logic [3:0] len, input logic [2:0] op,
                                input logic grp, input logic ill, input logic uns);
        rec_t r;
        r.opc = opc; r.esc = esc; r.md = modrm[7:6]; r.rg = modrm[5:3]; r.rm = modrm[2:0];
        r.grp = grp; r.disp = disp; r.imm = imm; r.len = len; r.op = op;
        r.ill = ill; r.uns = uns;
        return r;
    endfunction

    task automatic expect_rec(input rec_t r, input string tag);
        exp_q.push_back(r);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
        end else begin
            if (prev_v) begin
                checks++;
                if (rec_valid || !in_ready) begin
                    fails++;
                    $display("FAIL R10 after pulse: valid=%0b ready=%0b expected valid=0 ready=1",
                             rec_valid, in_ready);
                end
            end
            if (rec_valid) begin
                rec_t act;
                act = '{rec_opcode, rec_esc, rec_mod, rec_reg, rec_rm, rec_grp,
                        rec_disp, rec_imm, rec_len, rec_op, rec_illegal, rec_unsup};
                checks++;
                if (in_ready) begin
                    fails++;
                    $display("FAIL R10 ready during pulse: actual=1 expected=0");
                end
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11 unexpected record: actual=%h expected=none", act);
                end else begin
                    rec_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (act !== e) begin
                        fails++;
                        $display("FAIL %s record: actual=%h expected=%h", t, act, e);
                    end
                end
            end
            prev_v = rec_valid;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (!in_ready || rec_valid) begin
            fails++;
            $display("FAIL R1 reset state: ready=%0b valid=%0b expected ready=1 valid=0", in_ready, rec_valid);
        end

        // R3 R4: add, absolute 32-bit displacement
        expect_rec(mk(8'h03, 0, 8'h05, 32'h12345678, 8'h00, 4'd6, 3'd1, 0, 0, 0), "R4");
        send(8'h03, 0); send(8'h05, 0); send(8'h78, 0); send(8'h56, 0); send(8'h34, 0); send(8'h12, 0);

        // R6: escaped double shift with displacement then immediate
        expect_rec(mk(8'hA4, 1, 8'h05, 32'hDEADBEEF, 8'h03, 4'd8, 3'd5, 0, 0, 0), "R6");
        send(8'h0F, 0); send(8'hA4, 0); send(8'h05, 0);
        send(8'hEF, 0); send(8'hBE, 0); send(8'hAD, 0); send(8'hDE, 0); send(8'h03, 0);

        // R5: mod=01 negative and positive short displacement
        expect_rec(mk(8'h03, 0, 8'h4B, 32'hFFFFFFF0, 8'h00, 4'd3, 3'd1, 0, 0, 0), "R5");
        send(8'h03, 0); send(8'h4B, 0); send(8'hF0, 0);
        expect_rec(mk(8'h03, 0, 8'h4B, 32'h0000007F, 8'h00, 4'd3, 3'd1, 0, 0, 0), "R5");
        send(8'h03, 0); send(8'h4B, 0); send(8'h7F, 0);

        // R5 R3: mod=10 four bytes, opcode 0x01
        expect_rec(mk(8'h01, 0, 8'h93, 32'h44332211, 8'h00, 4'd6, 3'd2, 0, 0, 0), "R5");
        send(8'h01, 0); send(8'h93, 0); send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); send(8'h44, 0);

        // R5: mod=11 no displacement
        expect_rec(mk(8'h03, 0, 8'hC1, 32'h0, 8'h00, 4'd2, 3'd1, 0, 0, 0), "R5");
        send(8'h03, 0); send(8'hC1, 0);

        // R7: group opcode, register form with immediate
        expect_rec(mk(8'h80, 0, 8'hF8, 32'h0, 8'h05, 4'd3, 3'd3, 1, 0, 0), "R7");
        send(8'h80, 0); send(8'hF8, 0); send(8'h05, 0);

        // R7 R6: group opcode with absolute displacement and immediate
        expect_rec(mk(8'h80, 0, 8'h05, 32'h00000001, 8'hAA, 4'd7, 3'd3, 1, 0, 0), "R7");
        send(8'h80, 0); send(8'h05, 0); send(8'h01, 0); send(8'h00, 0);
        send(8'h00, 0); send(8'h00, 0); send(8'hAA, 0);

        // R8: scaled-index request, then next byte is a fresh opcode
        expect_rec(mk(8'h03, 0, 8'h04, 32'h0, 8'h00, 4'd2, 3'd1, 0, 0, 1), "R8");
        send(8'h03, 0); send(8'h04, 0);
        expect_rec(mk(8'h90, 0, 8'h00, 32'h0, 8'h00, 4'd1, 3'd4, 0, 0, 0), "R8");
        send(8'h90, 0);

        // R9: illegal one-byte opcode, then a no-op
        expect_rec(mk(8'hFF, 0, 8'h00, 32'h0, 8'h00, 4'd1, 3'd0, 0, 1, 0), "R9");
        send(8'hFF, 0);
        expect_rec(mk(8'h90, 0, 8'h00, 32'h0, 8'h00, 4'd1, 3'd4, 0, 0, 0), "R9");
        send(8'h90, 0);

        // R2: 0x03 after escape is illegal in the second-level table
        expect_rec(mk(8'h03, 1, 8'h00, 32'h0, 8'h00, 4'd2, 3'd0, 0, 1, 0), "R2");
        send(8'h0F, 0); send(8'h03, 0);

        // R3: escaped shift with register count
        expect_rec(mk(8'hA5, 1, 8'hD8, 32'h0, 8'h00, 4'd3, 3'd6, 0, 0, 0), "R3");
        send(8'h0F, 0); send(8'hA5, 0); send(8'hD8, 0);

        // R11: idle gaps between bytes
        expect_rec(mk(8'hA4, 1, 8'hC8, 32'h0, 8'h07, 4'd4, 3'd5, 0, 0, 0), "R11");
        send(8'h0F, 3); send(8'hA4, 2); send(8'hC8, 4); send(8'h07, 1);

        // R1: reset mid-instruction
        send(8'h03, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        checks++;
        if (!in_ready || rec_valid) begin
            fails++;
            $display("FAIL R1 mid reset: ready=%0b valid=%0b expected ready=1 valid=0", in_ready, rec_valid);
        end
        expect_rec(mk(8'h90, 0, 8'h00, 32'h0, 8'h00, 4'd1, 3'd4, 0, 0, 0), "R1");
        send(8'h90, 0);

        repeat (6) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11 missing records: actual=%0d pending expected=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule